// File: doc/BRIEF.md
# Paged Nonvolatile Memory Command Engine

This block executes programming commands against five separate byte spaces held in on-chip registers that stand in for flash. The spaces are a 2 KB code array, a 64-byte writable user signature, a 32-byte read-only factory signature, a fuse row and a set of lock bytes. A command carries an opcode, a byte address and a transfer length. Write bytes then follow on a valid/ready stream, and read bytes come back on another. Every transfer stays inside one 32-byte page.

Programming can only clear bits, so fuses and locks move toward the enabled state through ordinary writes. Each space has its own way back to the erased value. Fuses return through a row write with auto-erase. Code and locks return through chip erase, which keeps the engine busy for a fixed number of cycles.

Top module: `nvm_prog_engine`

## Requirements
- R1: After reset every writable byte (code, user signature, fuse row, lock bytes) reads FFh, `busy_o` is low, `cmd_ready_o` is high, and both `wdata_ready_o` and `rdata_valid_o` are low.
- R2: The code space is 2048 bytes, 64 pages of 32. Opcode 1 reads it and opcode 2 programs it. A program stores the old byte ANDed with the new byte. A read command raises `rdata_valid_o` in the cycle after it is accepted.
- R3: A read or write command moves `cmd_len_i`+1 bytes (1 to 32). The page bits of the address stay fixed, and the low 5 bits start at the given offset and count up modulo 32. No byte outside that page is touched.
- R4: The user signature is 64 bytes. Opcode 3 reads it and opcode 4 programs it with the same AND rule. Chip erase leaves it unchanged.
- R5: The factory signature is 32 bytes. Opcode 5 reads it, and byte i reads (30 + 37·i) mod 256. Opcode 6 accepts and consumes its data bytes but changes nothing.
- R6: The fuse row is 8 bytes, indexed by address mod 8. Opcode 7 reads it. A plain fuse write (opcode 8) ANDs the data in, so 00h enables a fuse and writing FFh cannot disable one.
- R7: A fuse write with auto-erase (opcode 9) first sets the whole fuse row to FFh and then programs the supplied bytes. Bytes not supplied read FFh afterwards.
- R8: There are 4 lock bytes, indexed by address mod 4. Opcode 10 reads them and opcode 11 programs them with the AND rule. Neither a plain write nor a fuse auto-erase can raise a lock bit.
- R9: Chip erase (opcode 12) sets the code array and the lock bytes to FFh and leaves the fuse row unchanged. `busy_o` is high for exactly ERASE_CYCLES cycles, starting the cycle after acceptance, and `cmd_ready_o` is low throughout.
- R10: Opcodes 0, 13, 14 and 15 are accepted, consume no data and change no byte. `cmd_ready_o` is high again in the next cycle.
- R11: While `rdata_valid_o` is high and `rdata_ready_i` is low, `rdata_o` holds its value. `wdata_ready_o` and `rdata_valid_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Engine idle and accepting a command |
| cmd_op_i | input | 4 | Opcode |
| cmd_addr_i | input | 11 | Start byte address |
| cmd_len_i | input | 5 | Byte count minus one |
| wdata_valid_i | input | 1 | Write byte offered |
| wdata_ready_o | output | 1 | Write byte taken |
| wdata_i | input | 8 | Write byte |
| rdata_valid_o | output | 1 | Read byte offered |
| rdata_ready_i | input | 1 | Read byte taken |
| rdata_o | output | 8 | Read byte |
| busy_o | output | 1 | Chip erase in progress |

## Verification
The assertions assume that a producer keeps `cmd_valid_i` and its fields steady until they are accepted, and that ERASE_CYCLES is at least one. The bench drives every input half a cycle before the edge that samples it, and it holds each command and data byte until it sees the matching ready. It takes read bytes only while `rdata_valid_o` is high, and it holds off `rdata_ready_i` on purpose to exercise the hold rule. Expected bytes come from a bench-side array model that applies the AND, wrap and erase rules stated in the requirements.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  localparam logic [3:0] OP_CODE_RD = 4'd1;
  localparam logic [3:0] OP_CODE_WR = 4'd2;
  localparam logic [3:0] OP_USIG_RD = 4'd3;
  localparam logic [3:0] OP_USIG_WR = 4'd4;
  localparam logic [3:0] OP_FSIG_RD = 4'd5;
  localparam logic [3:0] OP_FSIG_WR = 4'd6;
  localparam logic [3:0] OP_FUSE_RD = 4'd7;
  localparam logic [3:0] OP_FUSE_WR = 4'd8;
  localparam logic [3:0] OP_FUSE_AE = 4'd9;
  localparam logic [3:0] OP_LOCK_RD = 4'd10;
  localparam logic [3:0] OP_LOCK_WR = 4'd11;
  localparam logic [3:0] OP_ERASE   = 4'd12;

  typedef enum logic [2:0] {SP_CODE, SP_USIG, SP_FSIG, SP_FUSE, SP_LOCK} space_e;
  typedef enum logic [1:0] {K_NONE, K_READ, K_WRITE, K_ERASE} kind_e;

  typedef struct packed {
    kind_e  kind;
    space_e space;
    logic   auto_erase;
  } cmd_t;

  function automatic cmd_t decode_op(logic [3:0] op);
    cmd_t c;
    c = '{kind: K_NONE, space: SP_CODE, auto_erase: 1'b0};
    case (op)
      OP_CODE_RD: c = '{K_READ,  SP_CODE, 1'b0};
      OP_CODE_WR: c = '{K_WRITE, SP_CODE, 1'b0};
      OP_USIG_RD: c = '{K_READ,  SP_USIG, 1'b0};
      OP_USIG_WR: c = '{K_WRITE, SP_USIG, 1'b0};
      OP_FSIG_RD: c = '{K_READ,  SP_FSIG, 1'b0};
      OP_FSIG_WR: c = '{K_WRITE, SP_FSIG, 1'b0};
      OP_FUSE_RD: c = '{K_READ,  SP_FUSE, 1'b0};
      OP_FUSE_WR: c = '{K_WRITE, SP_FUSE, 1'b0};
      OP_FUSE_AE: c = '{K_WRITE, SP_FUSE, 1'b1};
      OP_LOCK_RD: c = '{K_READ,  SP_LOCK, 1'b0};
      OP_LOCK_WR: c = '{K_WRITE, SP_LOCK, 1'b0};
      OP_ERASE:   c = '{K_ERASE, SP_CODE, 1'b0};
      default:    c = '{K_NONE,  SP_CODE, 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/nvm_byte_store.sv
module nvm_byte_store #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fill_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);

  logic [7:0] mem_q [DEPTH];

  // programming only clears bits; fill returns every byte to the erased value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (fill_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= mem_q[wr_addr_i] & wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/nvm_sig_rom.sv
module nvm_sig_rom #(
  parameter int unsigned DEPTH = 32,
  parameter logic [7:0]  SEED  = 8'h1E,
  parameter logic [7:0]  STEP  = 8'h25,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);

  assign rd_data_o = SEED + STEP * 8'(rd_addr_i);

endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
  import nvm_pkg::*;
#(
  parameter int unsigned AW           = 11,
  parameter int unsigned PAGE_AW      = 5,
  parameter int unsigned ERASE_CYCLES = 40,
  localparam int unsigned CNT_W = $clog2(ERASE_CYCLES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [3:0]         cmd_op_i,
  input  logic [AW-1:0]      cmd_addr_i,
  input  logic [PAGE_AW-1:0] cmd_len_i,
  input  logic               wdata_valid_i,
  output logic               wdata_ready_o,
  output logic               rdata_valid_o,
  input  logic               rdata_ready_i,
  output logic               busy_o,
  output space_e             space_o,
  output logic [AW-1:0]      addr_o,
  output logic               byte_wr_o,
  output logic               fill_code_o,
  output logic               fill_fuse_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_RD, ST_ERASE} state_e;

  state_e                 state_q;
  space_e                 space_q;
  logic [AW-PAGE_AW-1:0]  page_q;
  logic [PAGE_AW-1:0]     off_q;
  logic [PAGE_AW-1:0]     remain_q;
  logic [CNT_W-1:0]       cnt_q;
  cmd_t                   dec;
  logic                   accept;
  logic                   step;

  assign dec    = decode_op(cmd_op_i);
  assign accept = cmd_valid_i && cmd_ready_o;
  assign step   = (state_q == ST_WR && wdata_valid_i) ||
                  (state_q == ST_RD && rdata_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      space_q  <= SP_CODE;
      page_q   <= '0;
      off_q    <= '0;
      remain_q <= '0;
      cnt_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          space_q  <= dec.space;
          page_q   <= cmd_addr_i[AW-1:PAGE_AW];
          off_q    <= cmd_addr_i[PAGE_AW-1:0];
          remain_q <= cmd_len_i;
          cnt_q    <= CNT_W'(ERASE_CYCLES);
          case (dec.kind)
            K_READ:  state_q <= ST_RD;
            K_WRITE: state_q <= ST_WR;
            K_ERASE: state_q <= ST_ERASE;
            default: state_q <= ST_IDLE;
          endcase
        end
        ST_WR, ST_RD: if (step) begin
          off_q <= off_q + 1'b1;  // wraps inside the page
          if (remain_q == '0) state_q <= ST_IDLE;
          else remain_q <= remain_q - 1'b1;
        end
        ST_ERASE: begin
          if (cnt_q == CNT_W'(1)) state_q <= ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o   = (state_q == ST_IDLE);
  assign wdata_ready_o = (state_q == ST_WR);
  assign rdata_valid_o = (state_q == ST_RD);
  assign busy_o        = (state_q == ST_ERASE);
  assign space_o       = space_q;
  assign addr_o        = {page_q, off_q};
  assign byte_wr_o     = (state_q == ST_WR) && wdata_valid_i;
  assign fill_code_o   = accept && (dec.kind == K_ERASE);
  assign fill_fuse_o   = accept && dec.auto_erase;

endmodule

// File: rtl/nvm_prog_engine.sv
module nvm_prog_engine
  import nvm_pkg::*;
#(
  parameter int unsigned CODE_BYTES   = 2048,
  parameter int unsigned USIG_BYTES   = 64,
  parameter int unsigned FSIG_BYTES   = 32,
  parameter int unsigned FUSE_BYTES   = 8,
  parameter int unsigned LOCK_BYTES   = 4,
  parameter int unsigned PAGE_BYTES   = 32,
  parameter int unsigned ERASE_CYCLES = 40,
  parameter logic [7:0]  SIG_SEED     = 8'h1E,
  parameter logic [7:0]  SIG_STEP     = 8'h25,
  localparam int unsigned AW      = $clog2(CODE_BYTES),
  localparam int unsigned PAGE_AW = $clog2(PAGE_BYTES),
  localparam int unsigned FSIG_AW = $clog2(FSIG_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [3:0]         cmd_op_i,
  input  logic [AW-1:0]      cmd_addr_i,
  input  logic [PAGE_AW-1:0] cmd_len_i,
  input  logic               wdata_valid_i,
  output logic               wdata_ready_o,
  input  logic [7:0]         wdata_i,
  output logic               rdata_valid_o,
  input  logic               rdata_ready_i,
  output logic [7:0]         rdata_o,
  output logic               busy_o
);

  localparam int unsigned NSTORE = 4;

  function automatic int unsigned depth_of(int idx);
    case (idx)
      0:       return CODE_BYTES;
      1:       return USIG_BYTES;
      2:       return FUSE_BYTES;
      default: return LOCK_BYTES;
    endcase
  endfunction

  function automatic space_e space_of(int idx);
    case (idx)
      0:       return SP_CODE;
      1:       return SP_USIG;
      2:       return SP_FUSE;
      default: return SP_LOCK;
    endcase
  endfunction

  space_e          space_q;
  logic [AW-1:0]   addr_q;
  logic            byte_wr;
  logic            fill_code;
  logic            fill_fuse;
  logic [NSTORE-1:0] fill_vec;
  logic [7:0]      rd_b [NSTORE];
  logic [7:0]      sig_b;

  nvm_cmd_seq #(
    .AW(AW), .PAGE_AW(PAGE_AW), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_seq (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_ready_o, .cmd_op_i, .cmd_addr_i, .cmd_len_i,
    .wdata_valid_i, .wdata_ready_o, .rdata_valid_o, .rdata_ready_i,
    .busy_o,
    .space_o(space_q), .addr_o(addr_q), .byte_wr_o(byte_wr),
    .fill_code_o(fill_code), .fill_fuse_o(fill_fuse)
  );

  // erase scope per store: code and locks by chip erase, fuses by auto-erase
  assign fill_vec = {fill_code, fill_fuse, 1'b0, fill_code};

  for (genvar g = 0; g < NSTORE; g++) begin : g_store
    localparam int unsigned DEPTH = depth_of(g);
    localparam int unsigned SAW   = $clog2(DEPTH);
    nvm_byte_store #(.DEPTH(DEPTH)) u_store (
      .clk_i, .rst_ni,
      .fill_i   (fill_vec[g]),
      .wr_en_i  (byte_wr && (space_q == space_of(g))),
      .wr_addr_i(addr_q[SAW-1:0]),
      .wr_data_i(wdata_i),
      .rd_addr_i(addr_q[SAW-1:0]),
      .rd_data_o(rd_b[g])
    );
  end

  nvm_sig_rom #(.DEPTH(FSIG_BYTES), .SEED(SIG_SEED), .STEP(SIG_STEP)) u_sig (
    .rd_addr_i(addr_q[FSIG_AW-1:0]),
    .rd_data_o(sig_b)
  );

  always_comb begin
    case (space_q)
      SP_CODE: rdata_o = rd_b[0];
      SP_USIG: rdata_o = rd_b[1];
      SP_FSIG: rdata_o = sig_b;
      SP_FUSE: rdata_o = rd_b[2];
      SP_LOCK: rdata_o = rd_b[3];
      default: rdata_o = 8'hFF;
    endcase
  end

endmodule

// File: rtl/nvm_prog_engine_chk.sv
module nvm_prog_engine_chk
  import nvm_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 40
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       cmd_ready_o,
  input logic [3:0] cmd_op_i,
  input logic       wdata_ready_o,
  input logic       rdata_valid_o,
  input logic       rdata_ready_i,
  input logic [7:0] rdata_o,
  input logic       busy_o
);

  logic [31:0] busy_run_q;
  logic        accept;
  logic        op_unknown;
  logic        op_read;

  assign accept     = cmd_valid_i && cmd_ready_o;
  assign op_unknown = (cmd_op_i == 4'd0) || (cmd_op_i > OP_ERASE);
  assign op_read    = (cmd_op_i == OP_CODE_RD) || (cmd_op_i == OP_USIG_RD) ||
                      (cmd_op_i == OP_FSIG_RD) || (cmd_op_i == OP_FUSE_RD) ||
                      (cmd_op_i == OP_LOCK_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_run_q <= '0;
    else if (busy_o) busy_run_q <= busy_run_q + 1;
    else busy_run_q <= '0;
  end

  p_read_starts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && op_read |=> rdata_valid_o);

  p_busy_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cmd_ready_o);

  p_erase_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (cmd_op_i == OP_ERASE) |=> busy_o);

  p_erase_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_run_q == ERASE_CYCLES));

  p_unknown_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && op_unknown |=> cmd_ready_o);

  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o && !rdata_ready_i |=> rdata_valid_o && $stable(rdata_o));

  p_dir_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdata_ready_o && rdata_valid_o));

endmodule

bind nvm_prog_engine nvm_prog_engine_chk #(.ERASE_CYCLES(ERASE_CYCLES)) u_chk (.*);

// File: tb/nvm_prog_engine_test.sv
module nvm_prog_engine_test;

  localparam int ERASE_N = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [10:0] cmd_addr = '0;
  logic [4:0] cmd_len = '0;
  logic       wdata_valid = 1'b0;
  logic [7:0] wdata = '0;
  logic       rdata_ready = 1'b0;
  logic       cmd_ready, wdata_ready, rdata_valid, busy;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem_m [5][2048];
  logic [7:0] buf_q [32];

  always #2 clk = ~clk;

  nvm_prog_engine #(.ERASE_CYCLES(ERASE_N)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len),
    .wdata_valid_i(wdata_valid), .wdata_ready_o(wdata_ready), .wdata_i(wdata),
    .rdata_valid_o(rdata_valid), .rdata_ready_i(rdata_ready), .rdata_o(rdata),
    .busy_o(busy)
  );

  // spaces: 0 code, 1 user sig, 2 factory sig, 3 fuse, 4 lock
  function automatic int sz(int sp);
    case (sp) 0: return 2048; 1: return 64; 2: return 32; 3: return 8; default: return 4; endcase
  endfunction
  function automatic logic [3:0] rd_op(int sp);
    case (sp) 0: return 4'd1; 1: return 4'd3; 2: return 4'd5; 3: return 4'd7; default: return 4'd10; endcase
  endfunction
  function automatic logic [3:0] wr_op(int sp);
    case (sp) 0: return 4'd2; 1: return 4'd4; 2: return 4'd6; 3: return 4'd8; default: return 4'd11; endcase
  endfunction
  function automatic int pidx(int sp, logic [10:0] a, int k);
    logic [10:0] x;
    x = {a[10:5], 5'(int'(a[4:0]) + k)};
    return int'(x) & (sz(sp) - 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(logic [3:0] op, logic [10:0] a, logic [4:0] lm1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_len = lm1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_wr(int sp, logic [10:0] a, int lm1, bit ae);
    send_cmd(ae ? 4'd9 : wr_op(sp), a, 5'(lm1));
    if (ae) for (int i = 0; i < 8; i++) mem_m[3][i] = 8'hFF;
    for (int k = 0; k <= lm1; k++) begin
      if (sp != 2) mem_m[sp][pidx(sp, a, k)] &= buf_q[k];
      wdata_valid = 1'b1; wdata = buf_q[k];
      while (!wdata_ready) @(negedge clk);
      @(negedge clk);
    end
    wdata_valid = 1'b0;
  endtask

  task automatic do_rd(string tag, int sp, logic [10:0] a, int lm1);
    send_cmd(rd_op(sp), a, 5'(lm1));
    rdata_ready = 1'b1;
    for (int k = 0; k <= lm1; k++) begin
      while (!rdata_valid) @(negedge clk);
      chk(tag, 32'(rdata), 32'(mem_m[sp][pidx(sp, a, k)]));
      @(negedge clk);
    end
    rdata_ready = 1'b0;
  endtask

  task automatic fill_buf(int seed, int mul);
    for (int k = 0; k < 32; k++) buf_q[k] = 8'(seed + mul * k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 5; s++)
      for (int i = 0; i < 2048; i++) mem_m[s][i] = 8'hFF;
    for (int i = 0; i < 32; i++) mem_m[2][i] = 8'(30 + 37 * i);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd_ready", 32'(cmd_ready), 1);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 wdata_ready", 32'(wdata_ready), 0);
    chk("R1 rdata_valid", 32'(rdata_valid), 0);
    do_rd("R1 code", 0, 11'h000, 31);
    do_rd("R1 usig", 1, 11'h020, 31);
    do_rd("R1 fuse", 3, 11'h000, 7);
    do_rd("R1 lock", 4, 11'h000, 3);

    // R2 every code page, then full readback
    for (int p = 0; p < 64; p++) begin
      fill_buf(p * 13 + 5, 7);
      do_wr(0, 11'(p * 32), 31, 1'b0);
    end
    for (int p = 0; p < 64; p++) do_rd("R2 code sweep", 0, 11'(p * 32), 31);
    // R2 AND on reprogram
    fill_buf(8'hF0, 3);
    do_wr(0, 11'(9 * 32), 31, 1'b0);
    do_rd("R2 and", 0, 11'(9 * 32), 31);

    // R3 wrap within page, neighbours untouched
    fill_buf(8'h3C, 5);
    do_wr(0, 11'(20 * 32 + 27), 9, 1'b0);
    do_rd("R3 wrap page", 0, 11'(20 * 32), 31);
    do_rd("R3 next page", 0, 11'(21 * 32), 31);
    do_rd("R3 prev page", 0, 11'(19 * 32), 31);
    do_rd("R3 wrap read", 0, 11'(20 * 32 + 31), 31);
    fill_buf(8'h00, 0);
    do_wr(0, 11'(40 * 32 + 17), 0, 1'b0);
    do_rd("R3 single", 0, 11'(40 * 32), 31);

    // R4 user signature
    fill_buf(8'h5A, 11);
    do_wr(1, 11'h000, 31, 1'b0);
    fill_buf(8'hA7, 9);
    do_wr(1, 11'h020, 31, 1'b0);
    do_rd("R4 usig p0", 1, 11'h000, 31);
    do_rd("R4 usig p1", 1, 11'h020, 31);

    // R5 factory signature is read-only
    do_rd("R5 fsig", 2, 11'h000, 31);
    fill_buf(8'h00, 0);
    do_wr(2, 11'h000, 31, 1'b0);
    do_rd("R5 fsig after write", 2, 11'h005, 31);

    // R6 fuse plain write can only enable
    for (int k = 0; k < 8; k++) buf_q[k] = (k % 3 == 0) ? 8'h00 : 8'hFF;
    do_wr(3, 11'h000, 7, 1'b0);
    fill_buf(8'hFF, 0);
    do_wr(3, 11'h000, 7, 1'b0);
    do_rd("R6 fuse", 3, 11'h000, 7);
    chk("R6 fuse0 enabled", 32'(mem_m[3][0]), 32'h00);

    // R8 locks: program, no way up except chip erase
    buf_q[0] = 8'h00; buf_q[1] = 8'hF0; buf_q[2] = 8'hFF; buf_q[3] = 8'h0F;
    do_wr(4, 11'h000, 3, 1'b0);
    fill_buf(8'hFF, 0);
    do_wr(4, 11'h000, 3, 1'b0);
    do_rd("R8 lock", 4, 11'h000, 3);

    // R7 auto-erase; locks unaffected (R8)
    buf_q[0] = 8'h00; buf_q[1] = 8'hFF; buf_q[2] = 8'h00;
    do_wr(3, 11'h002, 2, 1'b1);
    do_rd("R7 fuse ae", 3, 11'h000, 7);
    chk("R7 fuse0 disabled", 32'(mem_m[3][0]), 32'hFF);
    do_rd("R8 lock after ae", 4, 11'h000, 3);

    // R9 chip erase
    send_cmd(4'd12, 11'h000, 5'd0);
    begin
      int n = 0;
      while (busy) begin
        n++;
        chk("R9 ready low while busy", 32'(cmd_ready), 0);
        @(negedge clk);
      end
      chk("R9 busy cycles", n, ERASE_N);
    end
    for (int i = 0; i < 2048; i++) mem_m[0][i] = 8'hFF;
    for (int i = 0; i < 4; i++) mem_m[4][i] = 8'hFF;
    for (int p = 0; p < 64; p += 7) do_rd("R9 code erased", 0, 11'(p * 32), 31);
    do_rd("R9 lock erased", 4, 11'h000, 3);
    do_rd("R9 fuse kept", 3, 11'h000, 7);
    do_rd("R4 usig kept", 1, 11'h000, 31);
    do_rd("R4 usig kept p1", 1, 11'h020, 31);

    // R10 unknown opcodes
    fill_buf(8'h12, 1);
    do_wr(0, 11'h100, 31, 1'b0);
    foreach (buf_q[k]) buf_q[k] = 8'h00;
    for (int u = 0; u < 4; u++) begin
      logic [3:0] op;
      op = (u == 0) ? 4'd0 : 4'(12 + u);
      send_cmd(op, 11'h100, 5'd31);
      chk("R10 ready after unknown", 32'(cmd_ready), 1);
      chk("R10 no data taken", 32'(wdata_ready), 0);
      chk("R10 no read", 32'(rdata_valid), 0);
    end
    do_rd("R10 code unchanged", 0, 11'h100, 31);

    // R11 read back-pressure
    send_cmd(4'd1, 11'h104, 5'd3);
    begin
      logic [7:0] first;
      first = rdata;
      for (int w = 0; w < 5; w++) begin
        chk("R11 valid held", 32'(rdata_valid), 1);
        chk("R11 data held", 32'(rdata), 32'(first));
        chk("R11 no wdata_ready", 32'(wdata_ready), 0);
        @(negedge clk);
      end
      chk("R11 held value", 32'(first), 32'(mem_m[0][32'h104]));
    end
    rdata_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk("R11 stream", 32'(rdata), 32'(mem_m[0][32'h104 + k]));
      @(negedge clk);
    end
    rdata_ready = 1'b0;
    chk("R11 back to idle", 32'(cmd_ready), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule